// File: doc/BRIEF.md
# Impedance Calibration Sweep Sequencer

This block runs the search that sets the impedance codes of an output driver. A code is applied to an analog calibration cell and held while the cell settles. The single comparator bit from the cell is then sampled, and the next code follows. Two searches run one after the other. The first sweeps the pull-up drive code. The second sweeps the pull-down termination code while the pull-up result found by the first stays applied.

When the second search ends, the block turns the two search results into four result codes. A fixed pull-down drive code joins them. The packing and scaling of the four codes depend on whether termination is on or off, and the mode is sampled at start. The block also selects the comparator reference level for each phase. After calibration it falls back to a tracking level.

The settle time is a cycle count given at an input, so the block does not depend on the clock frequency. The analog cell and any register access lie outside the block.

Top module: `imp_cal_seq`

## Requirements
- R1: Within each search the applied code follows the order 0, 1, …, 15, 29, 30, 31. Codes 16 to 28 never appear.
- R2: Each code is held for `settle_cycles_i`+1 clock cycles, and the comparator is sampled in the last of them. A run that tries K codes in total raises `done_o` K·(`settle_cycles_i`+1) cycles after the clock edge that accepted start.
- R3: The pull-up search stops at the first code in order for which `cmp_i` is 1, and that code is its result. If no code qualifies, the result is 255, meaning "not found".
- R4: The termination search starts at code 0 only after the pull-up search ends, and drives `pd_field_o` (stage code 2). It stops at the first code for which `cmp_i` is 0; if none qualifies, its result is 255. During this search `pu_field_o` holds the low 5 bits of the pull-up result. During the pull-up search (stage code 1) `pd_field_o` is 0.
- R5: With termination off, the results are res0 = pull-up, res1 = termination, res2 = 0 and res3 = 15.
- R6: With termination on, the results are res0 = pull-up, res1 = 9 (the fixed pull-down code), res2 = 0 and res3 = termination. Any of res0, res1 or res3 whose value is 3 or less is multiplied by 3 before it is output.
- R7: `vref_o` is 27 in every phase when termination is on. With termination off it is 40 during the pull-up search, 33 during the termination search and 22 while idle (the tracking level).
- R8: `done_o` is a one-cycle pulse at the end of the termination search. `stage_o` is 0 when it rises, and the result outputs stay unchanged until the next run ends.
- R9: A start request during a run has no effect. `term_on_i` is sampled only at the accepted start.
- R10: After reset `stage_o`, both code fields, `done_o` and all results are 0, and `vref_o` is 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calibration run (accepted only when idle) |
| term_on_i | input | 1 | Termination mode for the run |
| cmp_i | input | 1 | Comparator result from the calibration cell |
| settle_cycles_i | input | 12 | Extra settle cycles per code |
| pu_field_o | output | 5 | Pull-up code applied to the cell |
| pd_field_o | output | 5 | Pull-down termination code applied to the cell |
| stage_o | output | 2 | 0 idle, 1 pull-up search, 2 termination search |
| vref_o | output | 6 | Comparator reference select |
| done_o | output | 1 | One-cycle end-of-run pulse |
| res0_o | output | 8 | Result slot 0 |
| res1_o | output | 8 | Result slot 1 |
| res2_o | output | 8 | Result slot 2 |
| res3_o | output | 8 | Result slot 3 |

## Verification
Some properties are checked on every cycle. The code never lands in the skipped range, and code 15 is always followed by 29. A code holds steady between samples, and the settle counter steps down by one. The termination search never goes back to the pull-up search. `done_o` is a single pulse seen only in idle, results hold while idle, and the latched mode cannot change during a run. Other behaviour can only be shown by the bench's scenarios, where a comparator model trips at a chosen code. These are the exact stop code of each search, the not-found value, the packing and ×3 scaling per mode, the total run length for several settle counts, and the ignored start with a changing mode input.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;
   typedef enum logic [1:0] {
      STG_IDLE   = 2'd0,
      STG_PULLUP = 2'd1,
      STG_TERM   = 2'd2
   } stage_e;
endpackage

// File: rtl/imp_cal_order.sv
// Trial code stepper: ascending order with an optional skipped range.
module imp_cal_order #(
   parameter int CODE_W   = 5,
   parameter bit SKIP_EN  = 1'b1,
   parameter int GAP_FROM = 15,
   parameter int GAP_TO   = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              step_i,
   output logic [CODE_W-1:0] code_o,
   output logic              last_o
);
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] FROM_C   = CODE_W'(GAP_FROM);
   localparam logic [CODE_W-1:0] TO_C     = CODE_W'(GAP_TO);

   generate
      if (SKIP_EN && (GAP_TO <= GAP_FROM + 1 || GAP_TO > (1 << CODE_W) - 1)) begin : g_bad_gap
         $error("imp_cal_order: skip range does not fit the code width");
      end
   endgenerate

   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] nxt;

   generate
      if (SKIP_EN) begin : g_skip
         always_comb nxt = (code_q == FROM_C) ? TO_C : code_q + 1'b1;
      end else begin : g_linear
         always_comb nxt = code_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    code_q <= '0;
      else if (restart_i)            code_q <= '0;
      else if (step_i && !last_o)    code_q <= nxt;
   end

   assign code_o = code_q;
   assign last_o = (code_q == CODE_MAX);

   assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !restart_i) |=> $stable(code_q));

   generate
      if (SKIP_EN) begin : g_skip_chk
         assert_gap_jump_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (step_i && !restart_i && code_q == FROM_C) |=> (code_q == TO_C));
         assert_gap_never_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !(code_q > FROM_C && code_q < TO_C));
      end
   endgenerate
endmodule

// File: rtl/imp_cal_settle.sv
// Settle down-counter: reloads on each applied code, expires at zero.
module imp_cal_settle #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             expire_o
);
   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("imp_cal_settle: counter width must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load_i)        cnt_q <= len_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == '0);

   assert_settle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/imp_cal_pack.sv
// Mode-dependent packing and small-value scaling of the result slots.
module imp_cal_pack #(
   parameter int RES_W     = 8,
   parameter int FIXED_PD  = 9,
   parameter int PAD_HI    = 15,
   parameter int SCALE_LIM = 3,
   parameter int SCALE_MUL = 3
) (
   input  logic             term_i,
   input  logic [RES_W-1:0] pu_i,
   input  logic [RES_W-1:0] tm_i,
   output logic [RES_W-1:0] slot_o [4]
);
   localparam logic [RES_W-1:0] PD_C  = RES_W'(FIXED_PD);
   localparam logic [RES_W-1:0] PAD_C = RES_W'(PAD_HI);
   localparam logic [RES_W-1:0] LIM_C = RES_W'(SCALE_LIM);

   generate
      if (SCALE_LIM * SCALE_MUL >= (1 << RES_W)) begin : g_bad_scale
         $error("imp_cal_pack: scaled value overflows the result width");
      end
   endgenerate

   function automatic logic [RES_W-1:0] scale(input logic [RES_W-1:0] v);
      return (v <= LIM_C) ? RES_W'(v * RES_W'(SCALE_MUL)) : v;
   endfunction

   always_comb begin
      if (term_i) begin
         slot_o[0] = scale(pu_i);
         slot_o[1] = scale(PD_C);
         slot_o[2] = '0;
         slot_o[3] = scale(tm_i);
      end else begin
         slot_o[0] = pu_i;
         slot_o[1] = tm_i;
         slot_o[2] = '0;
         slot_o[3] = PAD_C;
      end
   end
endmodule

// File: rtl/imp_cal_seq.sv
// Two-stage impedance calibration sweep sequencer (top).
module imp_cal_seq
   import imp_cal_pkg::*;
#(
   parameter int CODE_W    = 5,
   parameter int RES_W     = 8,
   parameter int SETTLE_W  = 12,
   parameter int VREF_W    = 6,
   parameter int VREF_TERM = 27,
   parameter int VREF_PU   = 40,
   parameter int VREF_PD   = 33,
   parameter int VREF_TRK  = 22,
   parameter bit SKIP_EN   = 1'b1,
   parameter int GAP_FROM  = 15,
   parameter int GAP_TO    = 29,
   parameter int FIXED_PD  = 9,
   parameter int PAD_HI    = 15,
   parameter int SCALE_LIM = 3,
   parameter int SCALE_MUL = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                term_on_i,
   input  logic                cmp_i,
   input  logic [SETTLE_W-1:0] settle_cycles_i,
   output logic [CODE_W-1:0]   pu_field_o,
   output logic [CODE_W-1:0]   pd_field_o,
   output logic [1:0]          stage_o,
   output logic [VREF_W-1:0]   vref_o,
   output logic                done_o,
   output logic [RES_W-1:0]    res0_o,
   output logic [RES_W-1:0]    res1_o,
   output logic [RES_W-1:0]    res2_o,
   output logic [RES_W-1:0]    res3_o
);
   localparam logic [RES_W-1:0] NONE   = {RES_W{1'b1}};
   localparam int               PAD_W  = RES_W - CODE_W;

   generate
      if (RES_W <= CODE_W) begin : g_bad_res
         $error("imp_cal_seq: result width must exceed code width");
      end
      if (VREF_TERM >= (1 << VREF_W) || VREF_PU >= (1 << VREF_W) ||
          VREF_PD >= (1 << VREF_W) || VREF_TRK >= (1 << VREF_W)) begin : g_bad_vref
         $error("imp_cal_seq: reference value exceeds its width");
      end
   endgenerate

   stage_e            stage_q;
   logic              term_q;
   logic              done_q;
   logic [RES_W-1:0]  pu_res_q;
   logic [RES_W-1:0]  tm_res_q;
   logic [RES_W-1:0]  res_q [4];

   logic [CODE_W-1:0] code;
   logic              last;
   logic              expire;
   logic              busy, go, sample;
   logic              pu_hit, pu_end, tm_hit, tm_end;
   logic [RES_W-1:0]  tm_final;
   logic [RES_W-1:0]  packed_slot [4];

   assign busy   = (stage_q != STG_IDLE);
   assign go     = start_i && !busy;
   assign sample = busy && expire;
   assign pu_hit = (stage_q == STG_PULLUP) && sample && cmp_i;
   assign pu_end = pu_hit || ((stage_q == STG_PULLUP) && sample && last);
   assign tm_hit = (stage_q == STG_TERM) && sample && !cmp_i;
   assign tm_end = tm_hit || ((stage_q == STG_TERM) && sample && last);
   assign tm_final = tm_hit ? {{PAD_W{1'b0}}, code} : tm_res_q;

   imp_cal_order #(
      .CODE_W(CODE_W), .SKIP_EN(SKIP_EN), .GAP_FROM(GAP_FROM), .GAP_TO(GAP_TO)
   ) u_order (
      .clk(clk), .rst_n(rst_n), .restart_i(go || pu_end), .step_i(sample),
      .code_o(code), .last_o(last)
   );

   imp_cal_settle #(.CNT_W(SETTLE_W)) u_settle (
      .clk(clk), .rst_n(rst_n), .load_i(go || sample),
      .len_i(settle_cycles_i), .expire_o(expire)
   );

   imp_cal_pack #(
      .RES_W(RES_W), .FIXED_PD(FIXED_PD), .PAD_HI(PAD_HI),
      .SCALE_LIM(SCALE_LIM), .SCALE_MUL(SCALE_MUL)
   ) u_pack (
      .term_i(term_q), .pu_i(pu_res_q), .tm_i(tm_final), .slot_o(packed_slot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= STG_IDLE;
         term_q   <= 1'b0;
         done_q   <= 1'b0;
         pu_res_q <= '0;
         tm_res_q <= '0;
         for (int i = 0; i < 4; i++) res_q[i] <= '0;
      end else begin
         done_q <= tm_end;
         if (go) begin
            stage_q  <= STG_PULLUP;
            term_q   <= term_on_i;
            pu_res_q <= NONE;
            tm_res_q <= NONE;
         end
         if (pu_end) begin
            stage_q <= STG_TERM;
            if (pu_hit) pu_res_q <= {{PAD_W{1'b0}}, code};
         end
         if (tm_end) begin
            stage_q  <= STG_IDLE;
            tm_res_q <= tm_final;
            for (int i = 0; i < 4; i++) res_q[i] <= packed_slot[i];
         end
      end
   end

   always_comb begin
      pu_field_o = '0;
      pd_field_o = '0;
      case (stage_q)
         STG_PULLUP: pu_field_o = code;
         STG_TERM: begin
            pu_field_o = pu_res_q[CODE_W-1:0];
            pd_field_o = code;
         end
         default: ;
      endcase
   end

   always_comb begin
      if (term_q) vref_o = VREF_W'(VREF_TERM);
      else begin
         case (stage_q)
            STG_PULLUP: vref_o = VREF_W'(VREF_PU);
            STG_TERM:   vref_o = VREF_W'(VREF_PD);
            default:    vref_o = VREF_W'(VREF_TRK);
         endcase
      end
   end

   assign stage_o = stage_q;
   assign done_o  = done_q;
   assign res0_o  = res_q[0];
   assign res1_o  = res_q[1];
   assign res2_o  = res_q[2];
   assign res3_o  = res_q[3];

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (stage_q == STG_IDLE));
   assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == STG_IDLE) |=> ($stable(res_q[0]) && $stable(res_q[1]) &&
                                 $stable(res_q[2]) && $stable(res_q[3])));
   assert_stage_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == STG_TERM) |=> (stage_q != STG_PULLUP));
   assert_mode_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(term_q));
   assert_pu_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q == STG_TERM) |=> $stable(pu_field_o) || (stage_q == STG_IDLE));
endmodule

// File: tb/imp_cal_seq_bench.sv
module imp_cal_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        term_on_i = 1'b0;
   logic        cmp_i;
   logic [11:0] settle_cycles_i = '0;
   logic [4:0]  pu_field_o, pd_field_o;
   logic [1:0]  stage_o;
   logic [5:0]  vref_o;
   logic        done_o;
   logic [7:0]  res0_o, res1_o, res2_o, res3_o;

   int total = 0;
   int bad = 0;
   int thr_pu = 0;
   int thr_t = 0;

   always #2 clk = ~clk;

   // Comparator model: trips at a chosen threshold per search.
   assign cmp_i = (stage_o == 2'd1) ? (int'(pu_field_o) >= thr_pu) :
                  (stage_o == 2'd2) ? (int'(pd_field_o) <  thr_t)  : 1'b0;

   imp_cal_seq u_imp_cal_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .term_on_i(term_on_i),
      .cmp_i(cmp_i), .settle_cycles_i(settle_cycles_i),
      .pu_field_o(pu_field_o), .pd_field_o(pd_field_o), .stage_o(stage_o),
      .vref_o(vref_o), .done_o(done_o), .res0_o(res0_o), .res1_o(res1_o),
      .res2_o(res2_o), .res3_o(res3_o)
   );

   function automatic int order_at(int i);
      return (i < 16) ? i : 29 + (i - 16);
   endfunction
   function automatic int first_hit(int thr);
      for (int i = 0; i < 19; i++) if (order_at(i) >= thr) return order_at(i);
      return 255;
   endfunction
   function automatic int tries(int thr);
      for (int i = 0; i < 19; i++) if (order_at(i) >= thr) return i + 1;
      return 19;
   endfunction
   function automatic int scl(int v);
      return (v <= 3) ? v * 3 : v;
   endfunction
   function automatic int exp_vref(bit term, int stg);
      if (term) return 27;
      if (stg == 1) return 40;
      if (stg == 2) return 33;
      return 22;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_cal(int tp, int tt, bit term, int n, bit poke);
      int cyc, kexp, pu_e, tm_e, idx_pu, idx_tm, prev_pu, prev_tm;
      int e0, e1, e2, e3;
      bit ord_ok, vref_ok, hold_ok, pd_ok;
      thr_pu = tp; thr_t = tt; settle_cycles_i = 12'(n);
      pu_e = first_hit(tp); tm_e = first_hit(tt);
      kexp = (tries(tp) + tries(tt)) * (n + 1);
      @(negedge clk); start_i = 1'b1; term_on_i = term;
      @(negedge clk); start_i = 1'b0; term_on_i = ~term;   // R9: mode ignored after start
      cyc = 0; idx_pu = -1; idx_tm = -1; prev_pu = -1; prev_tm = -1;
      ord_ok = 1; vref_ok = 1; hold_ok = 1; pd_ok = 1;
      while (!done_o && cyc < 5000) begin
         if (stage_o == 2'd1) begin
            if (int'(pu_field_o) != prev_pu) begin
               idx_pu++; prev_pu = int'(pu_field_o);
               if (prev_pu != order_at(idx_pu)) ord_ok = 0;
            end
            if (pd_field_o != 5'd0) pd_ok = 0;
         end else if (stage_o == 2'd2) begin
            if (int'(pd_field_o) != prev_tm) begin
               idx_tm++; prev_tm = int'(pd_field_o);
               if (prev_tm != order_at(idx_tm)) ord_ok = 0;
            end
            if (int'(pu_field_o) != (pu_e & 31)) hold_ok = 0;
         end
         if (int'(vref_o) != exp_vref(term, int'(stage_o))) vref_ok = 0;
         start_i = (poke && (cyc == 3 || cyc == 4 + n)) ? 1'b1 : 1'b0;  // R9
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      chk(ord_ok, "R1 code order", idx_pu + idx_tm, -1);
      chk(cyc == kexp, "R2 run length", cyc, kexp);
      chk(hold_ok && pd_ok, "R4 field hold", int'(pu_field_o), pu_e & 31);
      chk(vref_ok, "R7 reference select", int'(vref_o), exp_vref(term, int'(stage_o)));
      if (term) begin
         e0 = scl(pu_e); e1 = 9; e2 = 0; e3 = scl(tm_e);
      end else begin
         e0 = pu_e; e1 = tm_e; e2 = 0; e3 = 15;
      end
      chk(int'(res0_o) == e0, term ? "R6 slot0 (R3)" : "R5 slot0 (R3)", int'(res0_o), e0);
      chk(int'(res1_o) == e1, term ? "R6 slot1" : "R5 slot1 (R4)", int'(res1_o), e1);
      chk(int'(res2_o) == e2, "R5/R6 slot2", int'(res2_o), e2);
      chk(int'(res3_o) == e3, term ? "R6 slot3 (R4)" : "R5 slot3", int'(res3_o), e3);
      chk(stage_o == 2'd0, "R8 idle at done", int'(stage_o), 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R8 done pulse width", int'(done_o), 0);
      chk(int'(vref_o) == exp_vref(term, 0), "R7 tracking level", int'(vref_o), exp_vref(term, 0));
      for (int k = 0; k < 3; k++) begin
         term_on_i = ~term_on_i;
         @(negedge clk);
      end
      chk(int'(res0_o) == e0 && int'(res3_o) == e3, "R8 results held", int'(res0_o), e0);
   endtask

   initial begin
      #(4 * 200000);
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(stage_o == 2'd0 && done_o == 1'b0, "R10 reset stage/done", int'(stage_o), 0);
      chk(pu_field_o == 5'd0 && pd_field_o == 5'd0, "R10 reset fields", int'(pu_field_o), 0);
      chk(res0_o == 8'd0 && res1_o == 8'd0 && res2_o == 8'd0 && res3_o == 8'd0,
          "R10 reset results", int'(res0_o), 0);
      chk(vref_o == 6'd22, "R10 reset reference", int'(vref_o), 22);
      rst_n = 1'b1;
      @(negedge clk);
      // Directed corners
      run_cal(0, 0, 1'b1, 0, 1'b0);    // R6: zeros scale to zero
      run_cal(2, 1, 1'b1, 1, 1'b0);    // R6: 2->6, 1->3
      run_cal(3, 4, 1'b1, 2, 1'b1);    // R6 boundary 3->9, 4 kept; R9 poke
      run_cal(20, 16, 1'b0, 1, 1'b0);  // R1 jump to 29
      run_cal(40, 40, 1'b0, 0, 1'b0);  // R3/R4 not found
      run_cal(40, 2, 1'b1, 3, 1'b1);   // R3 not found, term on
      run_cal(31, 31, 1'b0, 4, 1'b0);  // last code hits
      // Random runs
      for (int r = 0; r < 14; r++) begin
         run_cal(int'($urandom_range(0, 34)), int'($urandom_range(0, 34)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 5)),
                 1'($urandom_range(0, 1)));
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule